// File: doc/BRIEF.md
# Oscillator-Count Thermal Level Monitor

This block estimates die temperature from a sensor ring oscillator whose frequency rises with heat. The oscillator output, asynchronous to the reference clock, is synchronized and its rising edges are counted during a short window. The window opens at the start of every repeat period. When a window closes, the total is latched as the current count, and a higher count means a hotter die.

Each latched count is compared against three programmable limits to pick a thermal level from 0 (cold) to 3 (critical). Level 1 and above can request voltage/frequency scaling. Level 2 and above can request a divide-by-two clock throttle. Level 3 can request an emergency reset. Every request has its own enable. An interrupt goes pending only when a level limit is crossed upward or the counter first overflows, and software clears it by writing the status word back.

Top module: `thermal_level_monitor`

## Requirements
- R1: After reset the control word reads 0, both limit words read all-ones in every limit field (0x3F003F and 0x3F when the count is 6 bits wide), status and count read 0, and every request output and `irq` are low.
- R2: Register map, selected by `bus_addr`: 0 control, 1 limits (L1 in [15:0], L2 in [31:16]), 2 limit L3 in [15:0], 3 status, 4 count in [15:0]. Writes take effect at the next clock edge. Reads are combinational.
- R3: Control word bits: [0] stop, [1] scaling-request enable, [2] throttle enable, [3] emergency-reset enable, [4] overflow interrupt enable, [5] throttle-level interrupt enable, [6] reset-level interrupt enable, [23:8] repeat period P in reference cycles, [31:24] window length W. Measuring runs only when stop is 0 and P and W are both nonzero.
- R4: Each measurement counts the synchronized rising edges of `sensor_osc` during the first min(W,P) cycles of a period. The total is latched into the count register when that window closes.
- R5: The count saturates at all-ones (0xFFFF at the default width). A saturated count reports status state code 5. Otherwise the state field [2:0] holds the thermal level.
- R6: Status bit [9] (valid) is low after reset or after a stop, and goes high when the first window after measuring starts has closed.
- R7: The level is the highest of 3, 2, 1 whose limit (L3, L2, L1) the latched count meets or exceeds, or 0 if none is met.
- R8: `scale_req` = enable and level >= 1, `throttle_req` = enable and level >= 2, `emerg_rst_req` = enable and level = 3. All three are registered and change only in the cycle the count register updates.
- R9: Status bit [8] and `irq` become set on a measurement that raises the level from below 2 to 2 or more (throttle-level interrupt enabled), from below 3 to 3 (reset-level interrupt enabled), or that first saturates the count (overflow interrupt enabled).
- R10: A measurement that keeps or lowers the level and does not newly saturate leaves the interrupt untouched.
- R11: Writing status with bit [8] set clears the pending interrupt. Writing status with bit [8] clear has no effect.
- R12: Setting stop halts counting, clears valid and holds count, level and requests. Clearing stop restarts with the same settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_osc | input | 1 | Raw sensor oscillator, asynchronous |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| scale_req | output | 1 | Voltage/frequency scaling request |
| throttle_req | output | 1 | Divide-by-two throttle request |
| emerg_rst_req | output | 1 | Emergency thermal reset request |
| irq | output | 1 | Pending interrupt |

## Verification
A register write lands on the following edge and reads are combinational, so every register readback is sampled one cycle after the write strobe, away from the edge. A count, level, request or interrupt appears only when a window closes. That is min(W,P) cycles after measuring starts, plus the two-flop synchronizer lead-in. The bench therefore changes the oscillator rate only while the block is stopped, and after resuming it waits three full periods before sampling. At that point the result is settled and comes from a window that saw only the new rate. The oscillator period always divides the window length, so the expected count is exact whatever the phase.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LIM12 = 3'd1,
    A_LIM3  = 3'd2,
    A_STAT  = 3'd3,
    A_CNT   = 3'd4
  } addr_e;

  localparam logic [2:0] STATE_OVF = 3'd5;
  localparam int unsigned CLR_BIT  = 8;

  typedef struct packed {
    logic [7:0]  win;
    logic [15:0] period;
    logic        spare;
    logic        irq_rst_en;
    logic        irq_div_en;
    logic        irq_ovf_en;
    logic        rst_en;
    logic        div_en;
    logic        dvfs_en;
    logic        stop;
  } ctrl_t;

  // Window length actually used: never longer than the repeat period.
  function automatic logic [15:0] eff_window(logic [15:0] period, logic [7:0] win);
    logic [15:0] w;
    w = {8'd0, win};
    return (w < period) ? w : period;
  endfunction

  // Highest limit reached by the count decides the level.
  function automatic logic [1:0] level_of(logic [15:0] c, logic [15:0] l1,
                                          logic [15:0] l2, logic [15:0] l3);
    if (c >= l3) return 2'd3;
    if (c >= l2) return 2'd2;
    if (c >= l1) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/tlm_edge_sync.sv
module tlm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tlm_meas.sv
module tlm_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [15:0]      period,
  input  logic [7:0]       win,
  input  logic             rise,
  output logic             done,
  output logic [CNT_W-1:0] sample,
  output logic [CNT_W-1:0] count_q,
  output logic             valid_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [15:0]      pcnt, wlen;
  logic [CNT_W-1:0] acc, acc_base;
  logic             in_win;

  assign wlen     = tlm_pkg::eff_window(period, win);
  assign in_win   = pcnt < wlen;
  assign done     = run && (pcnt == wlen - 16'd1);
  assign acc_base = (pcnt == 16'd0) ? '0 : acc;
  assign sample   = (acc_base == CMAX) ? CMAX : acc_base + CNT_W'(rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      acc     <= '0;
      count_q <= '0;
      valid_q <= 1'b0;
    end else if (!run) begin
      pcnt    <= '0;
      acc     <= '0;
      valid_q <= 1'b0;
    end else begin
      pcnt <= (pcnt == period - 16'd1) ? 16'd0 : pcnt + 16'd1;
      if (in_win) acc <= sample;
      if (done) begin
        count_q <= sample;
        valid_q <= 1'b1;
      end
    end
  end

  p_valid_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(done));
  p_count_at_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_q) |-> $past(done));
  p_stop_drops_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !valid_q);
endmodule

// File: rtl/tlm_level.sv
module tlm_level #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] sample,
  input  logic [CNT_W-1:0] lim1,
  input  logic [CNT_W-1:0] lim2,
  input  logic [CNT_W-1:0] lim3,
  input  tlm_pkg::ctrl_t   ctrl,
  output logic [1:0]       level_q,
  output logic             sat_q,
  output logic             scale_req,
  output logic             throttle_req,
  output logic             emerg_rst_req,
  output logic             irq_hit
);
  logic [1:0] lvl_new;
  logic       sat_new;

  assign lvl_new = tlm_pkg::level_of(16'(sample), 16'(lim1), 16'(lim2), 16'(lim3));
  assign sat_new = &sample;
  assign irq_hit = done &&
    ((ctrl.irq_div_en && lvl_new >= 2'd2 && level_q <  2'd2) ||
     (ctrl.irq_rst_en && lvl_new == 2'd3 && level_q != 2'd3) ||
     (ctrl.irq_ovf_en && sat_new && !sat_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q       <= 2'd0;
      sat_q         <= 1'b0;
      scale_req     <= 1'b0;
      throttle_req  <= 1'b0;
      emerg_rst_req <= 1'b0;
    end else if (done) begin
      level_q       <= lvl_new;
      sat_q         <= sat_new;
      scale_req     <= ctrl.dvfs_en && lvl_new != 2'd0;
      throttle_req  <= ctrl.div_en  && lvl_new >= 2'd2;
      emerg_rst_req <= ctrl.rst_en  && lvl_new == 2'd3;
    end
  end

  p_reset_needs_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_rst_req |-> level_q == 2'd3);
  p_throttle_needs_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    throttle_req |-> level_q >= 2'd2);
  p_requests_at_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({scale_req, throttle_req, emerg_rst_req}) |-> $past(done));
endmodule

// File: rtl/thermal_level_monitor.sv
module thermal_level_monitor #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        sensor_osc,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scale_req,
  output logic        throttle_req,
  output logic        emerg_rst_req,
  output logic        irq
);
  import tlm_pkg::*;

  localparam int PAD_W = 16 - CNT_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] lim1_q, lim2_q, lim3_q;
  logic             pend_q;
  logic             run, rise, done, valid, sat, irq_hit;
  logic [CNT_W-1:0] sample, count;
  logic [1:0]       level;
  logic [2:0]       state;
  logic             wr_stat_clr;

  assign run         = !ctrl_q.stop && ctrl_q.period != 16'd0 && ctrl_q.win != 8'd0;
  assign state       = sat ? STATE_OVF : {1'b0, level};
  assign wr_stat_clr = bus_wr && bus_addr == A_STAT && bus_wdata[CLR_BIT];
  assign irq         = pend_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim1_q <= '1;
      lim2_q <= '1;
      lim3_q <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  begin
          ctrl_q       <= ctrl_t'(bus_wdata);
          ctrl_q.spare <= 1'b0;
        end
        A_LIM12: begin
          lim1_q <= bus_wdata[CNT_W-1:0];
          lim2_q <= bus_wdata[16 +: CNT_W];
        end
        A_LIM3:  lim3_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (irq_hit)     pend_q <= 1'b1;
    else if (wr_stat_clr) pend_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_LIM12: bus_rdata = {{PAD_W{1'b0}}, lim2_q, {PAD_W{1'b0}}, lim1_q};
      A_LIM3:  bus_rdata = {16'd0, {PAD_W{1'b0}}, lim3_q};
      A_STAT:  bus_rdata = {22'd0, valid, pend_q, 5'd0, state};
      A_CNT:   bus_rdata = {16'd0, {PAD_W{1'b0}}, count};
      default: bus_rdata = '0;
    endcase
  end

  tlm_edge_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_in(sensor_osc), .rise(rise)
  );

  tlm_meas #(.CNT_W(CNT_W)) i_meas (
    .clk(clk_ref), .rst_n(rst_n), .run(run), .period(ctrl_q.period),
    .win(ctrl_q.win), .rise(rise), .done(done), .sample(sample),
    .count_q(count), .valid_q(valid)
  );

  tlm_level #(.CNT_W(CNT_W)) i_level (
    .clk(clk_ref), .rst_n(rst_n), .done(done), .sample(sample),
    .lim1(lim1_q), .lim2(lim2_q), .lim3(lim3_q), .ctrl(ctrl_q),
    .level_q(level), .sat_q(sat), .scale_req(scale_req),
    .throttle_req(throttle_req), .emerg_rst_req(emerg_rst_req),
    .irq_hit(irq_hit)
  );

  p_irq_from_close_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(irq) |-> $past(done));
  p_state_code_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    state inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5});
  p_stop_holds_count_r12: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!run && $past(!run)) |-> $stable(count));
  p_sat_reports_ovf_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (&count) |-> state == STATE_OVF);
endmodule

// File: tb/test_thermal_level_monitor.sv
`timescale 1ns/1ps
module test_thermal_level_monitor;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic        sensor_osc = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scale_req, throttle_req, emerg_rst_req, irq;

  int checks = 0;
  int errors = 0;
  int osc_per = 0;
  int ph = 0;

  // bench model
  int m_cnt = 0, m_lvl = 0;
  bit m_sat = 0, m_pend = 0, m_sc = 0, m_th = 0, m_er = 0;

  thermal_level_monitor #(.CNT_W(CW)) i_thermal_level_monitor (
    .clk_ref(clk_ref), .rst_n(rst_n), .sensor_osc(sensor_osc),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .scale_req(scale_req), .throttle_req(throttle_req),
    .emerg_rst_req(emerg_rst_req), .irq(irq)
  );

  always #4 clk_ref = ~clk_ref;

  initial forever begin
    @(negedge clk_ref);
    ph = ph + 1;
    sensor_osc = (osc_per != 0) && (ph % osc_per == 0);
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_ref);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk_ref);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk_ref);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic [31:0] cw(bit stop, int m, int n, logic [5:0] en);
    return {n[7:0], m[15:0], 1'b0, en, stop};
  endfunction

  function automatic int lvl_of(int c, int t1, int t2, int t3);
    int l;
    l = 0;
    if (c >= t1) l = 1;
    if (c >= t2) l = 2;
    if (c >= t3) l = 3;
    return l;
  endfunction

  // en: [0] scale [1] throttle [2] reset [3] ovf irq [4] throttle irq [5] reset irq
  task automatic step(int sp, int m, int n, int t1, int t2, int t3,
                      logic [5:0] en, bit clr);
    logic [31:0] v;
    int w, c, l;
    bit s;
    wr(3'd0, cw(1'b1, m, n, en));
    repeat (3) @(negedge clk_ref);
    rd(3'd3, v);
    chk("R12 valid cleared by stop", v[9], 0);
    rd(3'd4, v);
    chk("R12 count held at stop", v, m_cnt);
    chk("R12 requests held at stop", {scale_req, throttle_req, emerg_rst_req},
        {m_sc, m_th, m_er});
    if (clr) begin
      wr(3'd3, 32'h100);
      m_pend = 0;
      #1 chk("R11 W1C clears irq", irq, 0);
    end
    osc_per = sp;
    wr(3'd1, {t2[15:0], t1[15:0]});
    wr(3'd2, {16'd0, t3[15:0]});
    repeat (8) @(negedge clk_ref);
    rd(3'd4, v);
    chk("R12 no counting while stopped", v, m_cnt);
    wr(3'd0, cw(1'b0, m, n, en));
    rd(3'd3, v);
    chk("R6 valid low before first window", v[9], 0);
    repeat (3 * m) @(negedge clk_ref);
    w = (n < m) ? n : m;
    c = w / sp;
    if (c > CMAX) c = CMAX;
    s = (c == CMAX);
    l = lvl_of(c, t1, t2, t3);
    if ((en[4] && l >= 2 && m_lvl < 2) || (en[5] && l == 3 && m_lvl < 3) ||
        (en[3] && s && !m_sat)) m_pend = 1;
    m_cnt = c; m_lvl = l; m_sat = s;
    m_sc = en[0] && l >= 1; m_th = en[1] && l >= 2; m_er = en[2] && l == 3;
    rd(3'd4, v);
    chk("R4 R5 latched count", v, m_cnt);
    rd(3'd3, v);
    chk("R6 valid after window", v[9], 1);
    chk("R7 R5 state field", v[2:0], s ? 5 : l);
    chk("R9 R10 pending bit", v[8], m_pend);
    chk("R9 R10 irq pin", irq, m_pend);
    chk("R8 scale_req", scale_req, m_sc);
    chk("R8 throttle_req", throttle_req, m_th);
    chk("R8 emerg_rst_req", emerg_rst_req, m_er);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_ref);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int unsigned seed;
    int pers[5] = '{2, 4, 5, 10, 20};
    seed = $urandom(7);
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R1 control reset", v, 0);
    rd(3'd1, v); chk("R1 limits reset", v, 32'h003F003F);
    rd(3'd2, v); chk("R1 limit3 reset", v, 32'h3F);
    rd(3'd3, v); chk("R1 status reset", v, 0);
    rd(3'd4, v); chk("R1 count reset", v, 0);
    chk("R1 outputs reset", {scale_req, throttle_req, emerg_rst_req, irq}, 0);
    wr(3'd2, 32'hFFFF_0009);
    rd(3'd2, v); chk("R2 R3 limit3 field width", v, 32'h9);
    wr(3'd0, cw(1'b0, 40, 0, 6'h3F));
    repeat (100) @(negedge clk_ref);
    rd(3'd3, v); chk("R3 zero window does not measure", v[9], 0);

    // directed ladder
    step(5, 40, 20, 3, 6, 9, 6'h3F, 1);   // count 4 -> level 1
    step(20, 40, 20, 3, 6, 9, 6'h3F, 1);  // count 1 -> level 0
    step(2, 40, 20, 3, 6, 9, 6'h3F, 0);   // count 10 -> level 3, rising irq
    wr(3'd3, 32'h0);
    #1 chk("R11 write without clear bit keeps irq", irq, 1);
    step(2, 40, 20, 3, 6, 9, 6'h3F, 1);   // stays 3: no new irq
    step(10, 40, 20, 3, 6, 9, 6'h3F, 0);  // falls to 0: no irq
    step(2, 40, 20, 3, 6, 9, 6'h00, 0);   // level 3, all enables off
    step(2, 250, 200, 3, 6, 9, 6'h08, 1); // saturated count, overflow irq
    step(2, 250, 200, 3, 6, 9, 6'h08, 1); // still saturated: no irq
    step(4, 40, 20, 3, 6, 9, 6'h3F, 1);   // leave saturation

    for (int i = 0; i < 20; i++) begin
      step(pers[$urandom % 5], 40, 20, $urandom % 12, $urandom % 12,
           $urandom % 12, 6'($urandom), bit'($urandom % 2));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule